// File: doc/BRIEF.md
# Interpolated DDS Sine Generator

This block is a direct digital synthesis oscillator for a DAC. On every clock a 48-bit phase accumulator advances by a programmable step. A separately programmed phase offset is added to the accumulated phase, and the sum is turned into a signed 16-bit sine sample. The sample rate is always the clock rate, so the output frequency depends only on the step word.

Only one quarter of a sine period is stored. The table has 512 segments plus an end point, and its contents are computed from a sine function when the design is elaborated. The other three quarters are produced by reading the table backward and by negating the result. Two neighbouring table points are read in the same cycle through two independent read addresses. The phase bits below the table index then interpolate linearly between those two points.

Step and offset are loaded as a pair by a single strobe while the oscillator keeps running. This supports frequency modulation, chirps and immediate phase jumps. No internal state depends on earlier output samples.

Top module: `sine_dds`

## Requirements
- R1: While `rst` is high, `sample` is 0 and `sample_valid` is 0. Once `sample_valid` has risen, it stays high until the next reset.
- R2: On every clock the 48-bit accumulator adds the loaded step and wraps modulo 2^48. Each valid sample is within 3 LSB of 32767·sin(2π·P/2^48), where P is the accumulated phase plus the offset.
- R3: `freq_word` and `phase_word` are captured together, and only on an edge where `load` is high. When `load` is low, changes on those inputs have no effect on `sample`. A captured step is first added at the edge that follows its capture.
- R4: A newly loaded offset moves the output phase to the new angle, with no dependence on earlier samples.
- R5: Phase bits [47:46] give the quadrant. In quadrants 1 and 3 the 9-bit index in bits [45:37] is complemented, so the table is read backward. In quadrants 2 and 3 the value is negated. A valid sample is ≤ 0 when bit 47 of its phase is set, and ≥ 0 otherwise.
- R6: Phases 0, 2^46, 2^47 and 3·2^46 give exactly 0, 32767, 0 and -32767.
- R7: Bits [36:21] form an unsigned interpolation fraction between two neighbouring table points. At index 100 with half the fraction, the sample lies strictly between those two table values. Bits [20:0] are dropped.
- R8: `sample` never equals -32768.
- R9: A phase reaches `sample` 3 edges after it is formed, and a load reaches `sample` on the 4th edge after the strobe. `sample_valid` rises after the 3rd edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures step and offset together |
| freq_word | input | 48 | Phase step per clock |
| phase_word | input | 48 | Phase offset added to the accumulator |
| sample | output | 16 | Signed sine sample |
| sample_valid | output | 1 | Pipeline filled since reset |

## Verification
The assertions assume a synchronous reset that is high from time zero for at least one edge. They also assume that `load` and the two words are known and steady around each rising edge. The bench changes every input on the falling edge only and holds reset for several cycles before releasing it. The sign and step properties look back at most two edges, so they rely on reset having cleared the pipeline to phase zero.

// File: rtl/sine_dds.sv
module sine_dds #(
  parameter int ACC_W  = 48,
  parameter int IDX_W  = 9,
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ACC_W-1:0]        freq_word,
  input  logic [ACC_W-1:0]        phase_word,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PEAK  = (1 << (OUT_W - 1)) - 1;
  localparam int PH_W  = 2 + IDX_W + FRAC_W;
  localparam int LO_W  = ACC_W - PH_W;
  localparam int MUL_W = OUT_W + FRAC_W + 2;
  localparam real PI   = 3.14159265358979323846;

  function automatic logic signed [OUT_W-1:0] qsin(int k);
    real x;
    x = $sin(PI * real'(k) / real'(2 * DEPTH)) * real'(PEAK);
    return OUT_W'($rtoi(x + 0.5));
  endfunction

  logic signed [OUT_W-1:0] rom [DEPTH+1];
  for (genvar g = 0; g <= DEPTH; g++) begin : g_rom
    assign rom[g] = qsin(g);
  end

  logic [ACC_W-1:0] freq_r, off_r, acc;
  logic [PH_W-1:0]  ph_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_r <= '0;
      off_r  <= '0;
      acc    <= '0;
      ph_r   <= '0;
    end else begin
      if (load) begin
        freq_r <= freq_word;
        off_r  <= phase_word;
      end
      acc  <= acc + freq_r;
      ph_r <= PH_W'((acc + off_r) >> LO_W);
    end
  end

  wire [1:0]        quad  = ph_r[PH_W-1 -: 2];
  wire [IDX_W-1:0]  idx   = ph_r[PH_W-3 -: IDX_W];
  wire [FRAC_W-1:0] frac  = ph_r[FRAC_W-1:0];
  wire [IDX_W-1:0]  idx_m = quad[0] ? ~idx : idx;
  wire [IDX_W:0]    addr_a = {1'b0, idx_m} + {{IDX_W{1'b0}}, quad[0]};
  wire [IDX_W:0]    addr_b = {1'b0, idx_m} + {{IDX_W{1'b0}}, ~quad[0]};

  logic signed [OUT_W-1:0] va, vb;
  logic [FRAC_W-1:0]       fr_r;
  logic                    neg_r;
  logic [2:0]              vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      va    <= '0;
      vb    <= '0;
      fr_r  <= '0;
      neg_r <= 1'b0;
    end else begin
      va    <= rom[addr_a];
      vb    <= rom[addr_b];
      fr_r  <= frac;
      neg_r <= quad[1];
    end
  end

  wire signed [OUT_W:0]   diff = (OUT_W+1)'(vb) - (OUT_W+1)'(va);
  wire signed [MUL_W-1:0] prod = MUL_W'(diff) * MUL_W'($signed({1'b0, fr_r}));
  wire signed [MUL_W-1:0] step = prod >>> FRAC_W;
  wire signed [OUT_W:0]   mag  = (OUT_W+1)'(va) + (OUT_W+1)'(step);
  wire signed [OUT_W:0]   res  = neg_r ? -mag : mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample <= '0;
      vpipe  <= '0;
    end else begin
      sample <= OUT_W'(res);
      vpipe  <= {vpipe[1:0], 1'b1};
    end
  end

  assign sample_valid = vpipe[2];
endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
  parameter int ACC_W = 48,
  parameter int PH_W  = 27,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    load,
  input logic [ACC_W-1:0]        freq_word,
  input logic [ACC_W-1:0]        phase_word,
  input logic [ACC_W-1:0]        freq_r,
  input logic [ACC_W-1:0]        off_r,
  input logic [ACC_W-1:0]        acc,
  input logic [PH_W-1:0]         ph_r,
  input logic signed [OUT_W-1:0] sample,
  input logic                    sample_valid
);
  assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> sample_valid);

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc == $past(acc) + $past(freq_r));

  assert_hold_unloaded_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(freq_r) && $stable(off_r)));

  assert_capture_pair_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (freq_r == $past(freq_word) && off_r == $past(phase_word)));

  assert_sign_follows_half_R5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> ($past(ph_r[PH_W-1], 2) ? (sample <= 0) : (sample >= 0)));

  assert_no_min_code_R8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (sample != {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

bind sine_dds dds_checker #(.ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)) u_checker (
  .clk(clk), .rst(rst), .load(load), .freq_word(freq_word), .phase_word(phase_word),
  .freq_r(freq_r), .off_r(off_r), .acc(acc), .ph_r(ph_r),
  .sample(sample), .sample_valid(sample_valid)
);

// File: tb/tb_sine_dds.sv
module tb_sine_dds;
  localparam real TWO_PI = 6.28318530717958647692;
  localparam real PI     = 3.14159265358979323846;
  localparam real FULL   = 281474976710656.0;
  localparam real TOL    = 3.0;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               load = 1'b0;
  logic [47:0]        freq_word = '0;
  logic [47:0]        phase_word = '0;
  logic signed [15:0] sample;
  logic               sample_valid;

  sine_dds dut (.clk(clk), .rst(rst), .load(load), .freq_word(freq_word),
                .phase_word(phase_word), .sample(sample), .sample_valid(sample_valid));

  always #5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur_tag = "R2";

  logic [47:0] m_acc = '0, m_freq = '0, m_off = '0;
  logic [47:0] phq[$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_freq = '0; m_off = '0;
      phq.delete();
    end else begin
      phq.push_back(m_acc + m_off);
      m_acc = m_acc + m_freq;
      if (load) begin
        m_freq = freq_word;
        m_off  = phase_word;
      end
      if (phq.size() > 3) void'(phq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit  ev;
      real e;
      real d;
      ev = (phq.size() == 3);
      chk(sample_valid == ev, "R1", "valid flag", longint'(sample_valid), longint'(ev));
      if (ev) begin
        e = 32767.0 * $sin(TWO_PI * real'(phq[0]) / FULL);
        d = real'(sample) - e;
        if (d < 0.0) d = -d;
        chk(d <= TOL, cur_tag, "sample vs sine", longint'(sample), longint'($rtoi(e)));
        chk(sample >= -16'sd32767, "R8", "range", longint'(sample), -32767);
      end
    end
  end

  task automatic load_pair(logic [47:0] f, logic [47:0] p);
    freq_word  = f;
    phase_word = p;
    load       = 1'b1;
    @(negedge clk);
    load       = 1'b0;
  endtask

  task automatic settle_and_expect(logic [47:0] p, int exp, string tag);
    load_pair('0, p);
    repeat (6) @(negedge clk);
    chk(sample == 16'(exp), tag, "exact value", longint'(sample), longint'(exp));
  endtask

  initial begin
    #2000000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int lo;
    int hi;
    logic [47:0] f;
    repeat (4) @(negedge clk);
    chk(sample == 0, "R1", "sample in reset", longint'(sample), 0);
    chk(sample_valid == 0, "R1", "valid in reset", longint'(sample_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sample_valid == 0, "R9", "valid after 2 edges", longint'(sample_valid), 0);
    @(negedge clk);
    chk(sample_valid == 1, "R9", "valid after 3 edges", longint'(sample_valid), 1);

    cur_tag = "R6";
    settle_and_expect(48'd0, 0, "R6");
    settle_and_expect(48'd1 << 46, 32767, "R6");
    settle_and_expect(48'd1 << 47, 0, "R6");
    settle_and_expect(48'd3 << 46, -32767, "R6");

    settle_and_expect(48'd0, 0, "R9");
    load_pair('0, 48'd1 << 46);
    repeat (2) @(negedge clk);
    chk(sample == 0, "R9", "old value 3 edges after load", longint'(sample), 0);
    @(negedge clk);
    chk(sample == 32767, "R9", "new value 4 edges after load", longint'(sample), 32767);

    cur_tag = "R3";
    freq_word  = 48'h0123_4567_89AB;
    phase_word = 48'h8000_0000_0000;
    repeat (20) @(negedge clk);
    chk(sample == 32767, "R3", "unloaded words ignored", longint'(sample), 32767);

    cur_tag = "R7";
    load_pair('0, (48'd100 << 37) + (48'd1 << 36));
    repeat (6) @(negedge clk);
    lo = $rtoi(32767.0 * $sin(PI * 100.0 / 1024.0) + 0.5);
    hi = $rtoi(32767.0 * $sin(PI * 101.0 / 1024.0) + 0.5);
    chk(sample > 16'(lo) && sample < 16'(hi), "R7", "between neighbours",
        longint'(sample), longint'((lo + hi) / 2));
    load_pair('0, (48'd3 << 46) + (48'd511 << 37) + (48'hFFFF << 21));
    repeat (6) @(negedge clk);

    cur_tag = "R5";
    load_pair(48'h0041_8937_4BC6, 48'h0);
    repeat (2000) @(negedge clk);

    cur_tag = "R2";
    f = 48'd1 << 36;
    for (int k = 0; k < 1500; k++) begin
      f = f + (48'd1 << 26);
      freq_word = f;
      load = 1'b1;
      @(negedge clk);
    end
    load = 1'b0;

    cur_tag = "R4";
    for (int k = 0; k < 10; k++) begin
      load_pair(48'h7FF0_0000_0000 - 48'(k) * 48'h0000_1000_0000,
                48'(k) * 48'h1234_5678_9ABC);
      repeat (36) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule